// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is the bus-master end of a 32-bit asynchronous bus on which the slave ends each transfer by handshake. It runs one read or one write cycle at a time. A request from the core side carries an address, a direction, write data and a flag that marks an interrupt-acknowledge cycle. The block drives the address, the direction line and the three active-low strobes: address strobe, data strobe and data-buffer enable. On writes it also drives the data bus. It then waits as long as the slave needs and turns the slave's termination inputs into a single outcome.

The block runs on a clock at twice the bus clock rate, so one clock is half a bus clock. Each clock is one "step" below. All strobes come straight from flip-flops. The outcome is one of four kinds:

- normal acknowledge, which also carries the slave's port width;
- bus error;
- retry;
- autovector.

The outcome is reported with a one-step done pulse. Read data comes back on a separate output. Splitting an operand into several cycles is left to the requester, as are arbitration and error handling.

Top module: `bcyc_seq`

## Requirements
- R1: While reset is asserted and after it is released, as_n, ds_n and dben_n are high, data_oe, busy and done are low, and rdata is zero.
- R2: A read accepted at edge 0 (start high while idle) pulls as_n and ds_n low together at edge 1, pulls dben_n low at edge 2, and never asserts data_oe. rw_o is 1 for reads.
- R3: A write accepted at edge 0 pulls as_n and dben_n low at edge 1, raises data_oe with all 32 bits of the write data on data_o at edge 2, and pulls ds_n low at edge 3. rw_o is 0 for writes.
- R4: Termination inputs are first sampled at edge 4. While none of them terminates, every strobe holds (wait states). halt_n low on its own has no effect, and neither does avec_n low in a cycle that is not an interrupt acknowledge.
- R5: Acknowledge inputs are active low, with ack_n[1] the upper one and ack_n[0] the lower one. ack_n=00 ends the cycle with kind 0 (normal) and size 0 (32 bit). ack_n=01 gives size 1 (16 bit) and ack_n=10 gives size 2 (8 bit). Any kind other than normal reports size 3.
- R6: berr_n low ends the cycle with kind 1 (error). berr_n and halt_n low together end it with kind 2 (retry). Both hold whatever ack_n and avec_n show.
- R7: In an interrupt-acknowledge cycle, avec_n low ends the cycle with kind 3 (autovector). This takes priority over ack_n and yields to bus error and retry.
- R8: data_i is latched into rdata at the terminating edge only for a read that ends with kind 0. Any other ending leaves rdata unchanged.
- R9: If edge t terminates the cycle, done is high for exactly the step after edge t. All strobes go high at edge t+1, data_oe drops at edge t+2, and busy is high from edge 0 until edge t+2.
- R10: start while busy is ignored. addr_o, rw_o and data_o keep the values of the request in progress, and no extra cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a cycle; taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_iack | input | 1 | Request is an interrupt-acknowledge cycle |
| req_addr | input | 32 | Cycle address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-step pulse with the outcome |
| done_kind | output | 2 | 0 normal, 1 error, 2 retry, 3 autovector |
| done_size | output | 2 | 0 = 32, 1 = 16, 2 = 8 bit, 3 = none |
| rdata | output | 32 | Data latched on a normal read |
| addr_o | output | 32 | Bus address |
| rw_o | output | 1 | Bus direction, 1 = read |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| dben_n | output | 1 | Data-buffer enable, active low |
| data_o | output | 32 | Write data to the bus |
| data_oe | output | 1 | Drive enable for data_o |
| data_i | input | 32 | Read data from the bus |
| ack_n | input | 2 | Acknowledge pair, active low |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low |
| avec_n | input | 1 | Autovector request, active low |

## Verification
The bench mixes every termination input at once and checks the priority order. A decoder that ranked error above retry would report kind 1 where kind 2 is due. One that let autovector end a normal cycle would stop a read too early and latch the wrong width. During wait states it applies halt on its own and a stray autovector. A design that took either as a termination would drop its strobes early. It also checks the exact step of every strobe edge for both directions. A design that shared one strobe schedule between reads and writes would show ds_n or dben_n one or two steps off. It raises start in the middle of a cycle to catch a sequencer that reloads the address.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

    typedef enum logic [1:0] {
        END_OK    = 2'd0,
        END_BERR  = 2'd1,
        END_RETRY = 2'd2,
        END_AVEC  = 2'd3
    } end_kind_e;

    typedef enum logic [1:0] {
        PW_32   = 2'd0,
        PW_16   = 2'd1,
        PW_8    = 2'd2,
        PW_NONE = 2'd3
    } port_w_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ASRT,
        ST_DATA,
        ST_WAIT,
        ST_NEG,
        ST_REL
    } step_e;

    typedef struct packed {
        logic      hit;
        end_kind_e kind;
        port_w_e   width;
    } term_t;

    // active-low acknowledge pair to port width
    function automatic port_w_e ack_width(input logic [1:0] ackn);
        case (ackn)
            2'b00:   return PW_32;
            2'b01:   return PW_16;
            2'b10:   return PW_8;
            default: return PW_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bcyc_term_dec.sv
module bcyc_term_dec
    import bcyc_pkg::*;
(
    input  logic [1:0] ack_n,
    input  logic       berr_n,
    input  logic       halt_n,
    input  logic       avec_n,
    input  logic       iack,
    output term_t      term
);
    logic berr_a, halt_a, avec_a, ack_a;

    always_comb begin
        berr_a = ~berr_n;
        halt_a = ~halt_n;
        avec_a = ~avec_n & iack;
        ack_a  = ~(&ack_n);

        term.hit   = 1'b0;
        term.kind  = END_OK;
        term.width = PW_NONE;
        if (berr_a && halt_a) begin
            term.hit  = 1'b1;
            term.kind = END_RETRY;
        end else if (berr_a) begin
            term.hit  = 1'b1;
            term.kind = END_BERR;
        end else if (avec_a) begin
            term.hit  = 1'b1;
            term.kind = END_AVEC;
        end else if (ack_a) begin
            term.hit   = 1'b1;
            term.kind  = END_OK;
            term.width = ack_width(ack_n);
        end
    end
endmodule

// File: rtl/bcyc_fsm.sv
module bcyc_fsm
    import bcyc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic req_write,
    input  logic hit,
    output logic load,
    output logic capture,
    output logic busy,
    output logic as_n,
    output logic ds_n,
    output logic dben_n,
    output logic data_oe
);
    step_e state;
    logic  wr_q;

    assign load    = start && (state == ST_IDLE);
    assign capture = hit && (state == ST_WAIT);
    assign busy    = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wr_q    <= 1'b0;
            as_n    <= 1'b1;
            ds_n    <= 1'b1;
            dben_n  <= 1'b1;
            data_oe <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ADDR;
                        wr_q  <= req_write;
                    end
                end
                ST_ADDR: begin
                    state <= ST_ASRT;
                    as_n  <= 1'b0;
                    if (wr_q) dben_n <= 1'b0;
                    else      ds_n   <= 1'b0;
                end
                ST_ASRT: begin
                    state <= ST_DATA;
                    if (wr_q) data_oe <= 1'b1;
                    else      dben_n  <= 1'b0;
                end
                ST_DATA: begin
                    state <= ST_WAIT;
                    if (wr_q) ds_n <= 1'b0;
                end
                ST_WAIT: begin
                    if (hit) state <= ST_NEG;
                end
                ST_NEG: begin
                    state  <= ST_REL;
                    as_n   <= 1'b1;
                    ds_n   <= 1'b1;
                    dben_n <= 1'b1;
                end
                ST_REL: begin
                    state   <= ST_IDLE;
                    data_oe <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bcyc_dpath.sv
module bcyc_dpath
    import bcyc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          capture,
    input  logic          req_write,
    input  logic          req_iack,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] data_i,
    input  term_t         term,
    output logic          iack_q,
    output logic [AW-1:0] addr_o,
    output logic          rw_o,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic [1:0]    done_kind,
    output logic [1:0]    done_size
);
    always_ff @(posedge clk) begin
        if (rst) begin
            iack_q    <= 1'b0;
            addr_o    <= '0;
            rw_o      <= 1'b1;
            data_o    <= '0;
            rdata     <= '0;
            done      <= 1'b0;
            done_kind <= END_OK;
            done_size <= PW_NONE;
        end else begin
            done <= capture;
            if (load) begin
                iack_q <= req_iack;
                addr_o <= req_addr;
                rw_o   <= ~req_write;
                data_o <= req_write ? req_wdata : '0;
            end
            if (capture) begin
                done_kind <= term.kind;
                done_size <= term.width;
                if (rw_o && term.kind == END_OK) rdata <= data_i;
            end
        end
    end
endmodule

// File: rtl/bcyc_seq.sv
module bcyc_seq
    import bcyc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          req_write,
    input  logic          req_iack,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    done_kind,
    output logic [1:0]    done_size,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] addr_o,
    output logic          rw_o,
    output logic          as_n,
    output logic          ds_n,
    output logic          dben_n,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    ack_n,
    input  logic          berr_n,
    input  logic          halt_n,
    input  logic          avec_n
);
    term_t term;
    logic  load, capture, iack_q;

    bcyc_term_dec u_dec (
        .ack_n  (ack_n),
        .berr_n (berr_n),
        .halt_n (halt_n),
        .avec_n (avec_n),
        .iack   (iack_q),
        .term   (term)
    );

    bcyc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_write (req_write),
        .hit       (term.hit),
        .load      (load),
        .capture   (capture),
        .busy      (busy),
        .as_n      (as_n),
        .ds_n      (ds_n),
        .dben_n    (dben_n),
        .data_oe   (data_oe)
    );

    bcyc_dpath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .capture   (capture),
        .req_write (req_write),
        .req_iack  (req_iack),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .data_i    (data_i),
        .term      (term),
        .iack_q    (iack_q),
        .addr_o    (addr_o),
        .rw_o      (rw_o),
        .data_o    (data_o),
        .rdata     (rdata),
        .done      (done),
        .done_kind (done_kind),
        .done_size (done_size)
    );
endmodule

// File: rtl/bcyc_chk.sv
module bcyc_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic [1:0]    done_kind,
    input logic [1:0]    done_size,
    input logic [AW-1:0] addr_o,
    input logic          rw_o,
    input logic          as_n,
    input logic          ds_n,
    input logic          dben_n,
    input logic          data_oe
);
    // R2
    ds_inside_as_chk: assert property (@(posedge clk) disable iff (rst)
        !ds_n |-> !as_n);

    // R2
    rd_strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(as_n) && rw_o |-> !ds_n && !data_oe);

    // R3
    wr_dben_with_as_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(as_n) && !rw_o |-> !dben_n && ds_n);

    // R3
    wr_drive_next_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(as_n) && !rw_o |=> data_oe);

    // R9
    strobe_negate_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> as_n && ds_n && dben_n);

    // R9
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ##1 !data_oe && !busy);

    // R5
    ok_size_chk: assert property (@(posedge clk) disable iff (rst)
        done && done_kind == 2'd0 |-> done_size != 2'd3);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy) && busy |-> $stable(addr_o) && $stable(rw_o));
endmodule

bind bcyc_seq bcyc_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/bcyc_seq_bench.sv
`timescale 1ns/1ps
module bcyc_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, req_write, req_iack;
    logic [31:0] req_addr, req_wdata;
    logic        busy, done, rw_o, as_n, ds_n, dben_n, data_oe;
    logic [1:0]  done_kind, done_size;
    logic [31:0] rdata, addr_o, data_o, data_i;
    logic [1:0]  ack_n;
    logic        berr_n, halt_n, avec_n;

    int nvec = 0;
    int nbad = 0;
    logic [31:0] exp_rdata = '0;

    always #4 clk = ~clk;

    bcyc_seq u_bcyc_seq (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic term_hit(input logic [1:0] a, input logic b, input logic h,
                                      input logic v, input logic ia);
        return !b || (!v && ia) || (a != 2'b11);
    endfunction

    function automatic logic [1:0] term_kind(input logic [1:0] a, input logic b, input logic h,
                                             input logic v, input logic ia);
        if (!b && !h) return 2'd2;
        if (!b)       return 2'd1;
        if (!v && ia) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [1:0] term_size(input logic [1:0] k, input logic [1:0] a);
        if (k != 2'd0) return 2'd3;
        case (a)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    task automatic idle_term;
        ack_n = 2'b11; berr_n = 1'b1; halt_n = 1'b1; avec_n = 1'b1;
    endtask

    // one whole cycle; w wait steps; termination pattern sampled at edge t = 4 + w
    task automatic run_cycle(input logic wr, input logic ia, input logic [31:0] ad,
                             input logic [31:0] wd, input int w, input logic [1:0] a,
                             input logic b, input logic h, input logic v, input logic [31:0] rd);
        int t;
        logic [1:0] ek, es;
        t  = 4 + w;
        ek = term_kind(a, b, h, v, ia);
        es = term_size(ek, a);
        start = 1'b1; req_write = wr; req_iack = ia; req_addr = ad; req_wdata = wd;
        @(posedge clk);
        for (int k = 0; k <= t + 2; k++) begin
            @(negedge clk);
            if (k == 0) start = 1'b0;
            if (wr) begin
                chk(as_n, (k >= 1 && k <= t) ? 0 : 1, "R3 as_n");
                chk(dben_n, (k >= 1 && k <= t) ? 0 : 1, "R3 dben_n");
                chk(ds_n, (k >= 3 && k <= t) ? 0 : 1, "R3 ds_n");
                chk(data_oe, (k >= 2 && k <= t + 1) ? 1 : 0, "R3 R9 data_oe");
                if (data_oe) chk(data_o, wd, "R3 data_o");
            end else begin
                chk(as_n, (k >= 1 && k <= t) ? 0 : 1, "R2 as_n");
                chk(ds_n, (k >= 1 && k <= t) ? 0 : 1, "R2 ds_n");
                chk(dben_n, (k >= 2 && k <= t) ? 0 : 1, "R2 dben_n");
                chk(data_oe, 0, "R2 data_oe");
            end
            chk(busy, (k <= t + 1) ? 1 : 0, "R9 busy");
            chk(done, (k == t) ? 1 : 0, "R9 done");
            if (k <= t + 1) begin
                chk(addr_o, ad, "R10 addr_o");
                chk(rw_o, !wr, "R10 rw_o");
            end
            if (k == t) begin
                chk(done_kind, ek, "R5 R6 R7 done_kind");
                chk(done_size, es, "R5 done_size");
                if (!wr && ek == 2'd0) exp_rdata = rd;
                chk(rdata, exp_rdata, "R8 rdata");
            end
            // stray start while busy (R10)
            if (k == 2) begin
                start = 1'b1; req_write = !wr; req_addr = ~ad; req_wdata = ~wd;
            end
            if (k == 3) start = 1'b0;
            // wait-state distractors (R4)
            idle_term();
            data_i = $urandom;
            if (k >= 3 && k <= t - 2) begin
                if ($urandom_range(0, 1) == 0) halt_n = 1'b0;
                else if (!ia) avec_n = 1'b0;
            end
            if (k == t - 1) begin
                ack_n = a; berr_n = b; halt_n = h; avec_n = v; data_i = rd;
            end
        end
        chk(busy, 0, "R10 no extra cycle");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [1:0] a;
        logic b, h, v, wr, ia;
        void'($urandom(32'h5eed_0017));
        rst = 1'b1; start = 1'b0; req_write = 1'b0; req_iack = 1'b0;
        req_addr = '0; req_wdata = '0; data_i = '0;
        idle_term();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(as_n, 1, "R1 as_n");
        chk(ds_n, 1, "R1 ds_n");
        chk(dben_n, 1, "R1 dben_n");
        chk(data_oe, 0, "R1 data_oe");
        chk(busy, 0, "R1 busy");
        chk(done, 0, "R1 done");
        rst = 1'b0;
        @(negedge clk);
        chk(rdata, 0, "R1 rdata");
        chk(busy, 0, "R1 busy after release");

        // directed corners
        run_cycle(0, 0, 32'h1000_0000, 0, 0, 2'b00, 1, 1, 1, 32'hCAFE_F00D);  // R5 32-bit read
        run_cycle(0, 0, 32'h1000_0004, 0, 3, 2'b01, 1, 1, 1, 32'h1234_5678);  // R5 16-bit
        run_cycle(0, 0, 32'h1000_0008, 0, 1, 2'b10, 1, 1, 0, 32'h0BAD_0BAD);  // R4 avec ignored, 8-bit
        run_cycle(0, 0, 32'h2000_0000, 0, 2, 2'b00, 0, 1, 1, 32'hDEAD_BEEF);  // R6 error with ack, R8 hold
        run_cycle(0, 0, 32'h2000_0004, 0, 0, 2'b00, 0, 0, 1, 32'hDEAD_BEEF);  // R6 retry with ack
        run_cycle(1, 0, 32'h3000_0000, 32'hA5A5_5A5A, 4, 2'b11, 0, 0, 1, 0);  // R6 retry alone
        run_cycle(0, 1, 32'hFFFF_FFF0, 0, 1, 2'b00, 1, 1, 0, 32'h7777_7777);  // R7 avec beats ack
        run_cycle(0, 1, 32'hFFFF_FFF2, 0, 0, 2'b11, 0, 1, 0, 32'h6666_6666);  // R7 error beats avec
        run_cycle(1, 0, 32'h3000_0010, 32'hFFFF_FFFF, 0, 2'b01, 1, 1, 1, 0);  // R3 write 16-bit
        run_cycle(1, 1, 32'h3000_0020, 32'h0000_0001, 5, 2'b10, 1, 0, 1, 0); // R4 halt alone no effect

        // constrained random
        for (int n = 0; n < 250; n++) begin
            wr = $urandom_range(0, 1);
            ia = ($urandom_range(0, 3) == 0);
            a  = 2'($urandom_range(0, 3));
            b  = ($urandom_range(0, 3) != 0);
            h  = ($urandom_range(0, 2) != 0);
            v  = ($urandom_range(0, 2) != 0);
            if (!term_hit(a, b, h, v, ia)) a = 2'($urandom_range(0, 2));
            run_cycle(wr, ia, $urandom, $urandom, $urandom_range(0, 6), a, b, h, v, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule